// File: doc/BRIEF.md
# I2C Slave Controller with Buffer Overflow Protection

This block is a clocked I2C slave. It oversamples the SCL and SDA lines through synchronizers and finds the edges and the bus conditions from those samples. It drives SDA only as an open-drain pull-down enable. Firmware reaches the block through a small register port with four byte-wide registers: control, status, a shared receive/transmit data buffer, and the low byte of the own address. The block matches a 7-bit or a 10-bit own address. It acknowledges the address byte and every data byte that follows it, and it places each accepted byte in the data buffer. When the master reads, the block shifts the buffer out on SDA. It never stretches the clock, so firmware prepares each transmit byte while SCL is held low.

The block does not accept a byte while firmware has not drained the previous one. If the buffer-full flag or the overflow flag is set when a byte completes, the byte gets no ACK and the buffer keeps its old value. The interrupt flag is still raised, and the overflow flag is set when the buffer was full. Firmware can also switch the block to a mode in which only START and STOP conditions raise interrupts. In that mode firmware can run the bus as a master.

Top module: `i2cs_slave`

## Requirements
- R1: The control register (address 0) holds enable in bit 7, overflow in bit 6, own-address bits 9:8 in bits 5:4 and the mode in bits 3:0. While enable is 0, sda_oe stays 0 and bus activity changes no status bit, no interrupt and no buffer.
- R2: The status register (address 1) holds buffer-full in bit 0, read/write in bit 2, START-seen in bit 3, STOP-seen in bit 4 and the interrupt in bit 7, which also drives the irq port. A START sets bit 3 and clears bit 4, a STOP sets bit 4 and clears bit 3, and any write to the status register clears the interrupt.
- R3: In modes 1 and 5 (7-bit), an address byte whose bits 7:1 equal bits 6:0 of the own-address register (address 3) is acknowledged by pulling SDA low during the ninth clock. It is also loaded into the data buffer (address 2), sets buffer-full and the interrupt, and copies its bit 0 into read/write. Any other address byte gets no ACK and changes nothing.
- R4: Each data byte after a matched write address is shifted in MSB first on rising SCL, then acknowledged, loaded into the buffer, and sets buffer-full and the interrupt.
- R5: A byte that would be accepted while buffer-full or overflow is set gets no ACK and leaves the buffer unchanged. It still sets the interrupt, and it sets overflow when buffer-full was set. The slave then ignores the bus until the next START.
- R6: Reading the data buffer clears buffer-full. Overflow clears only through a write to the control register.
- R7: In modes 2 and 6 (10-bit), a first byte of 11110, own bits 9:8 and a 0 is acknowledged. It is followed by a byte equal to own bits 7:0, and both bytes are acknowledged and loaded.
- R8: After a full 10-bit match, a repeated START followed by the header with bit 0 = 1 is acknowledged and selects transmit. A STOP cancels the match, so that header alone is not acknowledged after a STOP.
- R9: In transmit, the buffer is sent MSB first. SDA changes only while SCL is low, and each byte raises the interrupt when the master's ACK bit is sampled. A master NACK ends the transfer.
- R10: Modes 5 and 6 also raise the interrupt on every START and STOP. Mode 8 raises only START/STOP interrupts and never acknowledges. Every other mode code leaves the slave idle.
- R11: sda_oe turns on only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | SDA pull-down enable (1 drives the line low) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the data buffer) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions check on every cycle that SDA stays released while the block is disabled and that the pull-down turns on only with SCL low. They also check that a rejected byte never alters the buffer, that overflow falls only after a control write, and that the bit counter stays in range. The bench's bus scenarios are needed to show address matching across all 128 seven-bit addresses, the 10-bit header and low-byte sequence with a repeated-START read, and the exact reject behaviour after an unread byte. The same scenarios show the transmitted bit values and the START/STOP-only interrupt modes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LOW,
    ST_RXD,
    ST_TXD
  } stage_e;

  localparam logic [3:0] MODE_S7      = 4'h1;
  localparam logic [3:0] MODE_S10     = 4'h2;
  localparam logic [3:0] MODE_S7_SP   = 4'h5;
  localparam logic [3:0] MODE_S10_SP  = 4'h6;
  localparam logic [3:0] MODE_SP_ONLY = 4'h8;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_OWN  = 2'd3;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ten_bit,
  input  logic              slave_on,
  input  logic              scl_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [9:0]        own_addr,
  input  logic              accept,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              load,
  output logic              reject,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rw_set,
  output logic              rw_val,
  output logic              tx_done,
  output logic              sda_oe
);
  stage_e             stage_q, stage_d, nxt_q, nxt_d, after_ack;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sr_q, sr_d, tx_q, tx_d, byte_in;
  logic               drv_q, drv_d, ack_q, ack_d, hi_q, hi_d;
  logic               hdr_ok, match, rx_stage, byte_end;

  always_comb begin
    byte_in   = {sr_q[BYTE_W-2:0], sda_s};
    hdr_ok    = (byte_in[7:3] == 5'b11110) && (byte_in[2:1] == own_addr[9:8]);
    match     = 1'b0;
    after_ack = ST_IDLE;
    case (stage_q)
      ST_HDR: begin
        if (ten_bit) begin
          match     = byte_in[0] ? (hdr_ok && hi_q) : hdr_ok;
          after_ack = byte_in[0] ? ST_TXD : ST_LOW;
        end else begin
          match     = (byte_in[7:1] == own_addr[6:0]);
          after_ack = byte_in[0] ? ST_TXD : ST_RXD;
        end
      end
      ST_LOW: begin
        match     = (byte_in == own_addr[7:0]);
        after_ack = ST_RXD;
      end
      ST_RXD: begin
        match     = 1'b1;
        after_ack = ST_RXD;
      end
      default: ;
    endcase
    rx_stage  = (stage_q == ST_HDR) || (stage_q == ST_LOW) || (stage_q == ST_RXD);
    byte_end  = rx_stage && scl_rise && (cnt_q == CNT_W'(7));
    start_evt = en && scl_s && sda_fall;
    stop_evt  = en && scl_s && sda_rise;
    load      = byte_end && match && accept;
    reject    = byte_end && match && !accept;
    rx_byte   = byte_in;
    rw_set    = load && (stage_q == ST_HDR);
    rw_val    = byte_in[0];
    tx_done   = (stage_q == ST_TXD) && scl_rise && (cnt_q == CNT_W'(8));
  end

  always_comb begin
    stage_d = stage_q;
    nxt_d   = nxt_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    tx_d    = tx_q;
    drv_d   = drv_q;
    ack_d   = ack_q;
    hi_d    = hi_q;
    if (!en) begin
      stage_d = ST_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
      hi_d    = 1'b0;
    end else if (start_evt) begin
      stage_d = slave_on ? ST_HDR : ST_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else if (stop_evt) begin
      stage_d = ST_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
      hi_d    = 1'b0;
    end else if (rx_stage) begin
      if (scl_rise) begin
        if (cnt_q < CNT_W'(8)) begin
          sr_d  = byte_in;
          cnt_d = cnt_q + CNT_W'(1);
        end else begin
          cnt_d = CNT_W'(9);
        end
        if (byte_end) begin
          ack_d = match && accept;
          nxt_d = (match && accept) ? after_ack : ST_IDLE;
          if (stage_q == ST_HDR) hi_d = (match && byte_in[0]) ? hi_q : 1'b0;
          if (stage_q == ST_LOW) hi_d = match && accept;
        end
      end else if (scl_fall) begin
        if (cnt_q == CNT_W'(8)) begin
          drv_d = ack_q;
        end else if (cnt_q == CNT_W'(9)) begin
          drv_d   = 1'b0;
          cnt_d   = '0;
          stage_d = nxt_q;
        end
      end
    end else if (stage_q == ST_TXD) begin
      if (scl_rise) begin
        if (cnt_q == '0) begin
          tx_d  = {tx_byte[BYTE_W-2:0], 1'b0};
          drv_d = ~tx_byte[BYTE_W-1];
        end
        if (cnt_q < CNT_W'(8)) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else begin
          cnt_d = CNT_W'(9);
          nxt_d = sda_s ? ST_IDLE : ST_TXD;
        end
      end else if (scl_fall) begin
        if (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(7)) begin
          drv_d = ~tx_q[BYTE_W-1];
          tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
        end else if (cnt_q == CNT_W'(8)) begin
          drv_d = 1'b0;
        end else if (cnt_q == CNT_W'(9)) begin
          drv_d   = 1'b0;
          cnt_d   = '0;
          stage_d = nxt_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      drv_q   <= 1'b0;
      ack_q   <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      nxt_q   <= nxt_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      tx_q    <= tx_d;
      drv_q   <= drv_d;
      ack_q   <= ack_d;
      hi_q    <= hi_d;
    end
  end

  // first transmit bit follows the buffer until the first rising SCL edge
  assign sda_oe = en && (drv_q ||
                  ((stage_q == ST_TXD) && (cnt_q == '0) && !tx_byte[BYTE_W-1]));

  // R4: bit position never passes the acknowledge slot
  assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(9));
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic scl_s, scl_rise, scl_fall, sda_s, sda_rise, sda_fall;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_i), .din(scl_i), .lvl(scl_s), .rise(scl_rise), .fall(scl_fall));
  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_i), .din(sda_i), .lvl(sda_s), .rise(sda_rise), .fall(sda_fall));

  logic              en_q, en_d, ovf_q, ovf_d, bf_q, bf_d, irq_q, irq_d;
  logic              s_q, s_d, p_q, p_d, rw_q, rw_d;
  logic [1:0]        ahi_q, ahi_d;
  logic [3:0]        mode_q, mode_d;
  logic [BYTE_W-1:0] own_q, own_d, buf_q, buf_d, rx_byte;
  logic              ten_bit, slave_on, sp_irq;
  logic              start_evt, stop_evt, load, reject, rw_set, rw_val, tx_done;
  logic              wr_ctrl, wr_stat, wr_data, wr_own, rd_data;

  assign ten_bit  = (mode_q == MODE_S10) || (mode_q == MODE_S10_SP);
  assign slave_on = ten_bit || (mode_q == MODE_S7) || (mode_q == MODE_S7_SP);
  assign sp_irq   = (mode_q == MODE_S7_SP) || (mode_q == MODE_S10_SP) ||
                    (mode_q == MODE_SP_ONLY);

  i2cs_engine u_eng (
    .clk(clk), .rst_n(rst_i), .en(en_q), .ten_bit(ten_bit), .slave_on(slave_on),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .own_addr({ahi_q, own_q}), .accept(!(bf_q || ovf_q)), .tx_byte(buf_q),
    .start_evt(start_evt), .stop_evt(stop_evt), .load(load), .reject(reject),
    .rx_byte(rx_byte), .rw_set(rw_set), .rw_val(rw_val), .tx_done(tx_done),
    .sda_oe(sda_oe));

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    wr_stat = reg_wr && (reg_addr == REG_STAT);
    wr_data = reg_wr && (reg_addr == REG_DATA);
    wr_own  = reg_wr && (reg_addr == REG_OWN);
    rd_data = reg_rd && (reg_addr == REG_DATA);

    en_d   = wr_ctrl ? reg_wdata[7]   : en_q;
    ahi_d  = wr_ctrl ? reg_wdata[5:4] : ahi_q;
    mode_d = wr_ctrl ? reg_wdata[3:0] : mode_q;
    own_d  = wr_own  ? reg_wdata      : own_q;

    ovf_d = ovf_q;
    if (reject && bf_q) ovf_d = 1'b1;
    else if (wr_ctrl)   ovf_d = reg_wdata[6];

    buf_d = buf_q;
    if (load)         buf_d = rx_byte;
    else if (wr_data) buf_d = reg_wdata;

    bf_d = bf_q;
    if (load)         bf_d = 1'b1;
    else if (rd_data) bf_d = 1'b0;

    irq_d = irq_q;
    if (load || reject || tx_done || (sp_irq && (start_evt || stop_evt))) irq_d = 1'b1;
    else if (wr_stat) irq_d = 1'b0;

    s_d = s_q;
    p_d = p_q;
    if (start_evt)     begin s_d = 1'b1; p_d = 1'b0; end
    else if (stop_evt) begin s_d = 1'b0; p_d = 1'b1; end

    rw_d = rw_set ? rw_val : rw_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q <= 1'b0; ovf_q <= 1'b0; bf_q <= 1'b0; irq_q <= 1'b0;
      s_q  <= 1'b0; p_q   <= 1'b0; rw_q <= 1'b0;
      ahi_q <= '0; mode_q <= '0; own_q <= '0; buf_q <= '0;
    end else begin
      en_q <= en_d; ovf_q <= ovf_d; bf_q <= bf_d; irq_q <= irq_d;
      s_q  <= s_d;  p_q   <= p_d;   rw_q <= rw_d;
      ahi_q <= ahi_d; mode_q <= mode_d; own_q <= own_d; buf_q <= buf_d;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {en_q, ovf_q, ahi_q, mode_q};
      REG_STAT: reg_rdata = {irq_q, 2'b00, p_q, s_q, rw_q, 1'b0, bf_q};
      REG_DATA: reg_rdata = buf_q;
      default:  reg_rdata = own_q;
    endcase
  end

  assign irq = irq_q;

  // R1: a disabled block never pulls SDA
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_i)
    !en_q |-> !sda_oe);
  // R11: pull-down only turns on during the SCL low phase
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(sda_oe) |-> !scl_s);
  // R5: a refused byte leaves the buffer untouched
  assert_reject_keeps_buf_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (reject && !wr_data) |=> $stable(buf_q));
  // R6: overflow falls only after a control write
  assert_ovf_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(ovf_q) |-> $past(wr_ctrl));
endmodule

// File: tb/i2cs_slave_test.sv
module i2cs_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 6;
  localparam logic [6:0] OWN7 = 7'h2A;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, scl_m, sda_m, reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  wire  [7:0] reg_rdata;
  wire        sda_oe, irq;
  wire        sda_line = sda_m & ~sda_oe;

  i2cs_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b0; tick(T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b1; tick(T);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(T);
      scl_m = 1'b1; tick(2*T);
      scl_m = 1'b0; tick(T);
    end
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    acked = (sda_line == 1'b0);
    tick(T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(T);
      scl_m = 1'b1; tick(T);
      b[i] = sda_line;
      tick(T);
      scl_m = 1'b0; tick(T);
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(T);
    scl_m = 1'b1; tick(2*T);
    scl_m = 1'b0; tick(T);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd, rx;
    logic       ak;
    logic [7:0] pats [7];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};

    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // reset state
    reg_read(2'd0, rd); chk("R1 reset ctrl", rd, 8'h00);
    reg_read(2'd1, rd); chk("R2 reset status", rd, 8'h00);
    chk("R1 reset sda_oe", sda_oe, 0);

    // disabled: address byte ignored
    reg_write(2'd3, {1'b0, OWN7});
    reg_write(2'd0, 8'h01);
    bus_start(); send_byte({OWN7, 1'b0}, ak); bus_stop();
    chk("R1 disabled ack", ak, 0);
    reg_read(2'd1, rd); chk("R1 disabled status", rd, 8'h00);
    chk("R1 disabled irq", irq, 0);

    // 7-bit address sweep over all 128 addresses
    reg_write(2'd0, 8'h81);
    for (int a = 0; a < 128; a++) begin
      reg_write(2'd1, 8'h00);
      bus_start();
      if (a == 0) begin
        reg_read(2'd1, rd); chk("R2 start flag", rd, 8'h08);
      end
      send_byte({a[6:0], 1'b0}, ak);
      bus_stop();
      chk("R3 sweep ack", ak, (a == OWN7) ? 1 : 0);
      reg_read(2'd1, rd);
      chk("R3 sweep status", rd, ((a == OWN7) ? 8'h81 : 8'h00) | 8'h10);
      if (a == OWN7) begin
        reg_read(2'd2, rd); chk("R3 address loaded", rd, {OWN7, 1'b0});
        reg_read(2'd1, rd); chk("R6 bf cleared by read", rd & 8'h01, 0);
      end
    end

    // data bytes after write match
    reg_write(2'd1, 8'h00);
    bus_start(); send_byte({OWN7, 1'b0}, ak); chk("R3 addr ack", ak, 1);
    reg_read(2'd2, rd);
    foreach (pats[k]) begin
      reg_write(2'd1, 8'h00);
      send_byte(pats[k], ak);
      chk("R4 data ack", ak, 1);
      reg_read(2'd1, rd); chk("R4 status bf irq", rd, 8'h89);
      reg_read(2'd2, rd); chk("R4 data value", rd, pats[k]);
    end
    bus_stop();

    // overflow: second byte while buffer full
    bus_start(); send_byte({OWN7, 1'b0}, ak); reg_read(2'd2, rd);
    send_byte(8'h11, ak); chk("R4 first byte ack", ak, 1);
    reg_write(2'd1, 8'h00);
    send_byte(8'h22, ak); chk("R5 full nack", ak, 0);
    reg_read(2'd1, rd); chk("R5 irq still set", rd, 8'h89);
    reg_read(2'd0, rd); chk("R5 overflow set", rd, 8'hC1);
    reg_read(2'd2, rd); chk("R5 buffer kept", rd, 8'h11);
    reg_read(2'd0, rd); chk("R6 overflow survives read", rd, 8'hC1);
    bus_stop();
    bus_start(); send_byte({OWN7, 1'b0}, ak); bus_stop();
    chk("R5 overflow alone nack", ak, 0);
    reg_read(2'd2, rd); chk("R5 buffer kept on addr", rd, 8'h11);
    reg_write(2'd0, 8'h81);
    reg_read(2'd0, rd); chk("R6 overflow cleared by write", rd, 8'h81);
    bus_start(); send_byte({OWN7, 1'b0}, ak); bus_stop();
    chk("R6 ack after clear", ak, 1);
    reg_read(2'd2, rd);

    // 7-bit read
    reg_write(2'd1, 8'h00);
    bus_start(); send_byte({OWN7, 1'b1}, ak); chk("R3 read addr ack", ak, 1);
    reg_read(2'd1, rd); chk("R3 rw bit", rd, 8'h8D);
    reg_read(2'd2, rd);
    reg_write(2'd2, 8'hC3); reg_write(2'd1, 8'h00);
    recv_byte(1'b1, rx); chk("R9 tx byte 1", rx, 8'hC3); chk("R9 tx irq", irq, 1);
    reg_write(2'd2, 8'h3E); reg_write(2'd1, 8'h00);
    recv_byte(1'b0, rx); chk("R9 tx byte 2", rx, 8'h3E); chk("R9 tx irq 2", irq, 1);
    chk("R9 released after nack", sda_oe, 0);
    bus_stop();

    // 10-bit: own = 0x2B5
    reg_write(2'd0, 8'hA2); reg_write(2'd3, 8'hB5);
    bus_start(); send_byte(8'hF4, ak); chk("R7 header ack", ak, 1);
    reg_read(2'd2, rd); chk("R7 header loaded", rd, 8'hF4);
    send_byte(8'hB5, ak); chk("R7 low ack", ak, 1);
    reg_read(2'd2, rd); chk("R7 low loaded", rd, 8'hB5);
    send_byte(8'h69, ak); chk("R7 data ack", ak, 1);
    reg_read(2'd2, rd); chk("R7 data loaded", rd, 8'h69);
    bus_start(); send_byte(8'hF5, ak); chk("R8 read header ack", ak, 1);
    reg_read(2'd1, rd); chk("R8 rw set", rd & 8'h04, 8'h04);
    reg_read(2'd2, rd);
    reg_write(2'd2, 8'h96);
    recv_byte(1'b0, rx); chk("R8 tx byte", rx, 8'h96);
    bus_stop();
    bus_start(); send_byte(8'hF6, ak); bus_stop(); chk("R7 wrong header nack", ak, 0);
    bus_start(); send_byte(8'hF4, ak); reg_read(2'd2, rd);
    send_byte(8'hB4, ak); bus_stop(); chk("R7 wrong low nack", ak, 0);
    bus_start(); send_byte(8'hF5, ak); bus_stop(); chk("R8 read after stop nack", ak, 0);

    // start/stop interrupt modes
    reg_write(2'd3, {1'b0, OWN7});
    reg_write(2'd0, 8'h85); reg_write(2'd1, 8'h00);
    bus_start(); chk("R10 start irq", irq, 1);
    reg_write(2'd1, 8'h00);
    send_byte({OWN7, 1'b0}, ak); chk("R10 sp mode still slave", ak, 1);
    reg_read(2'd2, rd); reg_write(2'd1, 8'h00);
    bus_stop(); reg_read(2'd1, rd); chk("R10 stop irq", rd, 8'h90);
    reg_write(2'd0, 8'h88); reg_write(2'd1, 8'h00);
    bus_start(); chk("R10 sp-only start irq", irq, 1);
    reg_write(2'd1, 8'h00);
    send_byte({OWN7, 1'b0}, ak); chk("R10 sp-only no ack", ak, 0);
    chk("R10 sp-only no byte irq", irq, 0);
    bus_stop(); chk("R10 sp-only stop irq", irq, 1);
    reg_write(2'd0, 8'h81); reg_write(2'd1, 8'h00);
    bus_start(); bus_stop(); chk("R10 plain mode no sp irq", irq, 0);
    reg_write(2'd0, 8'h83);
    bus_start(); send_byte({OWN7, 1'b0}, ak); bus_stop();
    chk("R10 unused mode idle", ak, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule